// File: doc/BRIEF.md
# Motor Speed Frequency-Lock Comparator

This block regulates spindle speed by comparing the period of a tachometer pulse train against a programmable reference period. The reference period is counted in cycles of a crystal-oscillator clock. The feedback input is asynchronous, so it is first brought into the oscillator domain. The block then measures the number of oscillator clocks between successive rising edges and compares that count with the reference count. The result is a corrective pulse on one of two charge-pump control outputs, which an external analogue pump turns into charge or discharge of a loop filter.

A motor that runs too slowly produces a long period, which raises the up request. A motor that runs too fast produces a short period, which raises the down request. The length of the request grows with the size of the error, up to a fixed ceiling. There is one correction per feedback edge. With a one-pulse-per-revolution source, that means at most one correction per revolution.

Software may change the reference count and the feedback source at any time. The new count takes effect at the next feedback edge, so a period already being measured is never split between two references. When the loop is disabled, the pump output enable drops and neither request is driven. From reset until the first complete period has been measured, a force-high request asks the filter to be held at full drive so the motor gets maximum starting torque.

Top module: `speed_fll_cmp`

## Requirements
- R1: `fb_pulse` passes through a two-stage synchroniser followed by a rising-edge detector. The pump response to a rising edge appears at the outputs on the third clock edge after `fb_pulse` is first sampled high. An edge is recognised only after `fb_pulse` has been sampled low.
- R2: The measured period is the number of `clk` cycles between two successive recognised rising edges. It saturates at 2^CNT_W-1 (4095 by default) and never wraps.
- R3: A measured period longer than the reference count drives `pump_up`. A shorter one drives `pump_dn`. An equal one drives neither. The two are never high together.
- R4: The request stays high for exactly min(|period − reference|, PULSE_MAX) cycles, where PULSE_MAX defaults to 48. A new measurement restarts the request with its own direction and length, even if the previous request is unfinished.
- R5: While `loop_en` is low, `pump_oe` is low and both `pump_up` and `pump_dn` are low. Any unfinished request is discarded, so re-enabling does not replay it.
- R6: `force_high` is 1 from reset until the first completed period measurement. That measurement ends at the second recognised rising edge after reset. After that, `force_high` stays 0 until the next reset.
- R7: `div_sel` is captured only at recognised rising edges. A period that ends at an edge is compared with the value captured at the edge that began it. Changes to `div_sel` between edges have no effect on that comparison.
- R8: The first recognised rising edge after reset produces no pump request.
- R9: While `rst` is high at a clock edge, the block clears its request state and sets `force_high` to 1, with `pump_up` and `pump_dn` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_pulse | input | 1 | Asynchronous speed-feedback pulse train |
| loop_en | input | 1 | Closes the speed loop when high |
| div_sel | input | CNT_W | Reference period in clock cycles |
| pump_up | output | 1 | Charge request (motor too slow) |
| pump_dn | output | 1 | Discharge request (motor too fast) |
| pump_oe | output | 1 | Pump output enable; low means high impedance |
| force_high | output | 1 | Hold filter at maximum drive for start-up |

## Verification
The assertions assume three things about the inputs:
- `fb_pulse` stays at each level for at least one clock, so every rise is seen by the synchroniser.
- `loop_en` and `div_sel` change only between clock edges.
- Reset is applied at the start of the run.

The stimulus changes every input just after the falling clock edge. Its periods span from much shorter than the reference to beyond the counter's saturation point, and the high time of each period is always between one cycle and one cycle less than the full period. `div_sel` and `loop_en` are changed at random points inside periods, which exercises the edge-aligned capture and the discard of unfinished requests.

// File: rtl/speed_fll_pkg.sv
package speed_fll_pkg;

    localparam int unsigned CNT_W_DEF       = 12;
    localparam int unsigned PULSE_MAX_DEF   = 48;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } pump_dir_e;

    // Direction of correction: long period means the motor is slow.
    function automatic pump_dir_e pump_dir(input int unsigned meas,
                                           input int unsigned refc);
        if (meas > refc)      return DIR_UP;
        else if (meas < refc) return DIR_DN;
        else                  return DIR_NONE;
    endfunction

    // Request length: absolute error, clipped to the ceiling.
    function automatic int unsigned pump_span(input int unsigned meas,
                                              input int unsigned refc,
                                              input int unsigned cap);
        int unsigned diff;
        diff = (meas > refc) ? (meas - refc) : (refc - meas);
        return (diff > cap) ? cap : diff;
    endfunction

endpackage

// File: rtl/fb_sync.sv
module fb_sync #(
    parameter int unsigned SYNC_STAGES = speed_fll_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_async,
    output logic rise
);
    localparam int unsigned SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], fb_async};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

    // R1: an edge pulse lasts one cycle
    a_r1_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int unsigned CNT_W = speed_fll_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_period
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (rise) begin
            cnt  <= CNT_ONE;
            seen <= 1'b1;
        end else if (cnt != CNT_MAX) begin
            cnt  <= cnt + CNT_ONE;
        end
    end

    assign meas_valid  = rise & seen;
    assign meas_period = cnt;

    // R2: a saturated count stays saturated until the next edge
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !rise) |=> cnt == CNT_MAX);

    // R8: no valid measurement before a first edge has been seen
    a_r8_first_edge_silent: assert property (@(posedge clk) disable iff (rst)
        (!seen && !rise) |=> !meas_valid);

endmodule

// File: rtl/pump_ctrl.sv
module pump_ctrl
    import speed_fll_pkg::*;
#(
    parameter int unsigned CNT_W     = CNT_W_DEF,
    parameter int unsigned PULSE_MAX = PULSE_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_period,
    input  logic [CNT_W-1:0] div_sel,
    input  logic             loop_en,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             force_high
);
    localparam int unsigned PW_W = $clog2(PULSE_MAX + 1);
    localparam logic [PW_W-1:0] PW_CAP = PW_W'(PULSE_MAX);
    localparam logic [PW_W-1:0] PW_ONE = PW_W'(1);

    logic [CNT_W-1:0] ref_q;
    logic [PW_W-1:0]  pw;
    pump_dir_e        dir_q;
    logic             force_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            pw      <= '0;
            dir_q   <= DIR_NONE;
            force_q <= 1'b1;
        end else begin
            if (rise) ref_q <= div_sel;
            if (meas_valid) begin
                force_q <= 1'b0;
                dir_q   <= pump_dir(int'(meas_period), int'(ref_q));
            end
            if (!loop_en)
                pw <= '0;
            else if (meas_valid)
                pw <= PW_W'(pump_span(int'(meas_period), int'(ref_q), PULSE_MAX));
            else if (pw != '0)
                pw <= pw - PW_ONE;
        end
    end

    assign pump_up    = loop_en && (pw != '0) && (dir_q == DIR_UP);
    assign pump_dn    = loop_en && (pw != '0) && (dir_q == DIR_DN);
    assign force_high = force_q;

    // R3: never charge and discharge together
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pump_up && pump_dn));

    // R4: request length never exceeds the ceiling
    a_r4_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        pw <= PW_CAP);

    // R6: start-up hold, once released, stays released
    a_r6_force_sticky: assert property (@(posedge clk) disable iff (rst)
        !force_high |=> !force_high);

    // R6: start-up hold persists until a measurement completes
    a_r6_force_hold: assert property (@(posedge clk) disable iff (rst)
        (force_high && !meas_valid) |=> force_high);

    // R7: reference changes only at feedback edges
    a_r7_ref_hold: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(ref_q));

endmodule

// File: rtl/speed_fll_cmp.sv
module speed_fll_cmp
    import speed_fll_pkg::*;
#(
    parameter int unsigned CNT_W       = CNT_W_DEF,
    parameter int unsigned PULSE_MAX   = PULSE_MAX_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_pulse,
    input  logic             loop_en,
    input  logic [CNT_W-1:0] div_sel,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_oe,
    output logic             force_high
);
    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_period;

    fb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .fb_async (fb_pulse),
        .rise     (rise)
    );

    period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .meas_valid  (meas_valid),
        .meas_period (meas_period)
    );

    pump_ctrl #(.CNT_W(CNT_W), .PULSE_MAX(PULSE_MAX)) u_pump (
        .clk         (clk),
        .rst         (rst),
        .rise        (rise),
        .meas_valid  (meas_valid),
        .meas_period (meas_period),
        .div_sel     (div_sel),
        .loop_en     (loop_en),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .force_high  (force_high)
    );

    assign pump_oe = loop_en;

    // R5: a disabled pump drives no request
    a_r5_hiz_quiet: assert property (@(posedge clk) disable iff (rst)
        !pump_oe |-> (!pump_up && !pump_dn));

    // R9: reset leaves the block requesting full drive and no pump action
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (force_high && !pump_up && !pump_dn));

endmodule

// File: tb/speed_fll_cmp_test.sv
module speed_fll_cmp_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int PULSE_MAX  = 48;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fb_pulse = 1'b0;
    logic             loop_en = 1'b1;
    logic [CNT_W-1:0] div_sel = 12'd200;
    logic             pump_up, pump_dn, pump_oe, force_high;

    always #(CLK_PERIOD/2) clk = ~clk;

    speed_fll_cmp #(.CNT_W(CNT_W), .PULSE_MAX(PULSE_MAX), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .fb_pulse(fb_pulse), .loop_en(loop_en),
        .div_sel(div_sel), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_oe(pump_oe), .force_high(force_high)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R9";

    // Reference model state, from the requirements
    int       t = 0;
    logic [3:0] hist = '0;
    bit       m_have = 1'b0;
    int       m_prev = 0;
    int       m_ref  = 0;
    int       m_rem  = 0;
    int       m_dir  = 0;   // 0 none, 1 up, 2 down
    bit       m_force = 1'b1;

    function automatic int exp_dir(input int p, input int r);
        if (p > r) return 1;
        if (p < r) return 2;
        return 0;
    endfunction

    function automatic int exp_len(input int p, input int r);
        int d;
        d = (p > r) ? p - r : r - p;
        return (d > PULSE_MAX) ? PULSE_MAX : d;
    endfunction

    task automatic step(input logic fb_v);
        logic [3:0] got, exp;
        bit ev, valid;
        int p, w;
        @(negedge clk);
        t++;
        if (rst) begin
            // R9: reset state
            hist = '0; m_have = 0; m_ref = 0; m_rem = 0; m_dir = 0; m_force = 1;
        end else begin
            ev = hist[2] & ~hist[3];       // R1: rise seen 3 edges later
            valid = 0; w = 0;
            if (ev) begin
                if (m_have) begin          // R8: first edge is not a measurement
                    p = t - 3 - m_prev;
                    if (p > CMAX) p = CMAX; // R2: saturation
                    m_dir = exp_dir(p, m_ref);
                    w = exp_len(p, m_ref);
                    m_force = 0;           // R6
                    valid = 1;
                end
                m_have = 1;
                m_prev = t - 3;
                m_ref = int'(div_sel);     // R7: captured at the edge
            end
            if (!loop_en)       m_rem = 0; // R5
            else if (valid)     m_rem = w; // R4
            else if (m_rem > 0) m_rem--;
        end
        exp = {loop_en && m_rem > 0 && m_dir == 1,
               loop_en && m_rem > 0 && m_dir == 2,
               loop_en, m_force};
        got = {pump_up, pump_dn, pump_oe, force_high};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0d up/dn/oe/force got %b exp %b", cur_req, t, got, exp);
        end
        fb_pulse = fb_v;
        hist = {hist[2:0], fb_v};
    endtask

    // One feedback period of p cycles, high for hi; optional div change at chg
    task automatic period(input int p, input int hi, input int chg, input int nd);
        for (int i = 0; i < p; i++) begin
            if (i == chg) div_sel = CNT_W'(nd);
            step(i < hi);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R9: reset state
        cur_req = "R9";
        repeat (4) step(1'b0);
        rst = 1'b0;
        // R8 + R6: first edge silent, second edge measures 150 vs 200 -> down capped
        cur_req = "R8";
        repeat (3) step(1'b0);
        period(150, 40, -1, 0);
        cur_req = "R6";
        period(150, 40, -1, 0);
        // R3: slow, fast, equal
        cur_req = "R3";
        period(230, 60, -1, 0);
        period(170, 60, -1, 0);
        period(200, 1, -1, 0);
        period(200, 199, -1, 0);
        // R4: large error capped, restart mid-request with short periods
        cur_req = "R4";
        period(300, 100, -1, 0);
        period(20, 5, -1, 0);
        period(20, 10, -1, 0);
        period(201, 100, -1, 0);
        period(200, 100, -1, 0);
        // R7: reference changed mid-period, random points
        cur_req = "R7";
        for (int k = 0; k < 20; k++) begin
            int p, hi, chg, nd;
            p   = 150 + int'($urandom_range(100));
            hi  = 1 + int'($urandom_range(p - 2));
            chg = int'($urandom_range(p - 1));
            nd  = 150 + int'($urandom_range(100));
            period(p, hi, chg, nd);
        end
        div_sel = 12'd200;
        period(200, 50, -1, 0);
        // R5: disable mid-request, run disabled, re-enable
        cur_req = "R5";
        period(260, 50, -1, 0);
        repeat (10) step(1'b1);
        loop_en = 1'b0;
        repeat (240) step(1'b0);
        period(240, 50, -1, 0);
        period(150, 50, -1, 0);
        loop_en = 1'b1;
        repeat (20) step(1'b0);
        period(180, 50, -1, 0);
        // R2: period beyond counter range saturates
        cur_req = "R2";
        period(4300, 100, -1, 0);
        period(200, 100, -1, 0);
        // R1: random trains with narrow and wide high phases
        cur_req = "R1";
        for (int k = 0; k < 25; k++) begin
            int p, hi;
            p  = 100 + int'($urandom_range(200));
            hi = ($urandom_range(1) == 0) ? 1 : p - 1;
            period(p, hi, -1, 0);
        end
        // R6 + R9: reset mid-run restores start-up hold
        cur_req = "R6";
        rst = 1'b1;
        repeat (3) step(1'b0);
        rst = 1'b0;
        repeat (5) step(1'b0);
        period(210, 30, -1, 0);
        period(210, 30, -1, 0);
        period(190, 30, -1, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL %s watchdog expired got running exp finished", cur_req);
            summary();
            $finish;
        end
    end

endmodule